// File: doc/BRIEF.md
# Dual-Reload PWM and Event Timer

This block is a down-counting timer that holds two reload values and uses them in turn. In waveform mode it steps at either the fast clock rate or a divided-down slow rate. Every time the count passes through zero it reloads, alternating between the two values, and it can flip an output pin on each reload. One reload value therefore sets the high phase and the other sets the low phase, and the waveform runs with no further writes from software. In event mode the count steps on synchronized edges of an external input instead, and each pass through zero raises a single flag.

Each reload source has its own sticky pending flag and its own interrupt enable. Software can therefore take an interrupt on the rising edge of the waveform, on the falling edge, or on both. A small write-only register port loads the reload values, the counter preset and the control word, and it clears the pending flags.

Top module: `dual_reload_timer`

## Requirements
- R1: The counter is 16 bits and counts down by one per step. A step taken at zero is an underflow, so a reload value N gives N+1 steps between underflows.
- R2: The first underflow after a control write reloads from value A. The underflows after it reload from B, then A, then B, and so on.
- R3: In waveform mode with toggling on, each underflow flips `pwm_out`. The high phase lasts A+1 steps and the low phase lasts B+1 steps. With no underflow and no control write, `pwm_out` holds its value.
- R4: An underflow that reloads from A sets pending flag A, and one that reloads from B sets pending flag B. A flag stays set until a write to address 3 with bit 0 (flag A) or bit 1 (flag B) set. If that write lands in the same cycle as a new setting underflow, the flag stays set.
- R5: `irq_a` is high exactly when flag A and enable A are both set, and `irq_b` follows the same rule with its own flag and enable. Both outputs are registered and change in the same cycle as their flag.
- R6: With the high-speed bit at 1, the timer steps on every clock. With it at 0, the timer steps once per 10 clocks. The bit resets to 0.
- R7: Mode 2 counts rising edges of `ev_in` and mode 3 counts falling edges. Each edge passes a two-flop synchronizer and gives exactly one step. Edges of the other polarity are ignored.
- R8: In event mode an underflow always reloads from A and sets only flag A. It never sets flag B and never flips `pwm_out`.
- R9: Any write to the control register drives `pwm_out` low and restarts the alternation, so the next underflow reloads from A.
- R10: After reset, `pwm_out`, `irq_a` and `irq_b` are 0, both flags are clear and the mode is stopped.
- R11: The write addresses are 0 for reload A, 1 for reload B, 2 for control, 3 for flag clear and 4 for counter preset. The control word holds the mode in bits 2:0 (1 waveform, 2 event rising, 3 event falling), toggle enable in bit 3, enable A in bit 4, enable B in bit 5 and high speed in bit 6. A preset write takes priority over a step in the same cycle.
- R12: Mode values other than 1, 2 and 3 stop the counter, so no underflow occurs and `pwm_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (fast rate) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| ev_in | input | 1 | External event input, asynchronous |
| pwm_out | output | 1 | Toggling waveform output |
| irq_a | output | 1 | Interrupt for reloads from A |
| irq_b | output | 1 | Interrupt for reloads from B |

## Verification
Most internal faults show on `pwm_out` within one waveform period. A broken alternation flag makes the high and low phases swap or become equal. An off-by-one counter or a wrong prescaler stretches each phase by a fixed number of clocks, and the bench measures phase widths to the clock. Faults in the pending flags appear on `irq_a`/`irq_b` one clock after the underflow or the clear write. The enable-toggling and collision scenarios separate a lost flag from a masked one.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam logic [2:0] ADDR_REL_A = 3'd0;
  localparam logic [2:0] ADDR_REL_B = 3'd1;
  localparam logic [2:0] ADDR_CTRL  = 3'd2;
  localparam logic [2:0] ADDR_CLR   = 3'd3;
  localparam logic [2:0] ADDR_CNT   = 3'd4;

  localparam logic [2:0] MODE_WAVE    = 3'd1;
  localparam logic [2:0] MODE_EV_RISE = 3'd2;
  localparam logic [2:0] MODE_EV_FALL = 3'd3;

  localparam int CTRL_BITS = 7;

  typedef struct packed {
    logic       hs;
    logic       en_b;
    logic       en_a;
    logic       tog;
    logic [2:0] mode;
  } ctrl_t;
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);
endmodule

// File: rtl/drt_edge_sync.sv
module drt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/drt_count_core.sv
module drt_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wave,
  input  logic         tog_en,
  input  logic         restart,
  input  logic         preset_we,
  input  logic [W-1:0] preset_val,
  input  logic [W-1:0] rel_a,
  input  logic [W-1:0] rel_b,
  output logic [W-1:0] cnt,
  output logic         out,
  output logic         uflow,
  output logic         load_a,
  output logic         load_b
);
  logic use_b;

  assign uflow  = step && !preset_we && (cnt == '0);
  assign load_b = uflow && wave && use_b;
  assign load_a = uflow && !load_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      use_b <= 1'b0;
      out   <= 1'b0;
    end else begin
      if (preset_we) begin
        cnt <= preset_val;
      end else if (step) begin
        if (cnt == '0) begin
          cnt <= load_b ? rel_b : rel_a;
          if (wave) begin
            use_b <= ~use_b;
            if (tog_en) out <= ~out;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (restart) begin
        use_b <= 1'b0;
        out   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer #(
  parameter int W           = 16,
  parameter int PRESCALE    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ev_in,
  output logic         pwm_out,
  output logic         irq_a,
  output logic         irq_b
);
  import drt_pkg::*;

  logic [W-1:0] rel_a, rel_b, cnt;
  ctrl_t        ctrl_q, ctrl_d;
  logic         ctrl_wr, clr_a, clr_b, preset_we;
  logic         is_pwm, is_evt, tick, ev_rise, ev_fall, count_en;
  logic         uflow, load_a, load_b;
  logic         pend_a, pend_b, pend_a_d, pend_b_d;
  logic         en_a, hs, tog_en;

  wire unused_hi = ^wr_data[W-1:CTRL_BITS];

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign preset_we = wr_en && (wr_addr == ADDR_CNT);
  assign clr_a     = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];
  assign clr_b     = wr_en && (wr_addr == ADDR_CLR) && wr_data[1];
  assign ctrl_d    = ctrl_wr ? ctrl_t'(wr_data[CTRL_BITS-1:0]) : ctrl_q;

  assign is_pwm = (ctrl_q.mode == MODE_WAVE);
  assign is_evt = (ctrl_q.mode == MODE_EV_RISE) || (ctrl_q.mode == MODE_EV_FALL);
  assign en_a   = ctrl_q.en_a;
  assign hs     = ctrl_q.hs;
  assign tog_en = ctrl_q.tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_a  <= '0;
      rel_b  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && wr_addr == ADDR_REL_A) rel_a <= wr_data;
      if (wr_en && wr_addr == ADDR_REL_B) rel_b <= wr_data;
      ctrl_q <= ctrl_d;
    end
  end

  drt_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  drt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ev_in),
    .rise(ev_rise),
    .fall(ev_fall)
  );

  always_comb begin
    if (is_pwm)      count_en = ctrl_q.hs | tick;
    else if (is_evt) count_en = (ctrl_q.mode == MODE_EV_FALL) ? ev_fall : ev_rise;
    else             count_en = 1'b0;
  end

  drt_count_core #(.W(W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .step      (count_en),
    .wave      (is_pwm),
    .tog_en    (ctrl_q.tog),
    .restart   (ctrl_wr),
    .preset_we (preset_we),
    .preset_val(wr_data),
    .rel_a     (rel_a),
    .rel_b     (rel_b),
    .cnt       (cnt),
    .out       (pwm_out),
    .uflow     (uflow),
    .load_a    (load_a),
    .load_b    (load_b)
  );

  assign pend_a_d = load_a | (pend_a & ~clr_a);
  assign pend_b_d = load_b | (pend_b & ~clr_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      pend_a <= pend_a_d;
      pend_b <= pend_b_d;
      irq_a  <= pend_a_d & ctrl_d.en_a;
      irq_b  <= pend_b_d & ctrl_d.en_b;
    end
  end
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         pwm_out,
  input logic         irq_a,
  input logic         pend_a,
  input logic         pend_b,
  input logic         clr_a,
  input logic         en_a,
  input logic         hs,
  input logic         tog_en,
  input logic         is_pwm,
  input logic         is_evt,
  input logic         ctrl_wr,
  input logic         uflow,
  input logic         load_a,
  input logic         count_en,
  input logic         preset_we,
  input logic [W-1:0] cnt
);
  p_count_down_r1: assert property (@(posedge clk) disable iff (rst)
    (count_en && !preset_we && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && tog_en && uflow && !ctrl_wr) |=> (pwm_out != $past(pwm_out)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!(is_pwm && tog_en && uflow) && !ctrl_wr) |=> $stable(pwm_out));

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_a && !clr_a) |=> pend_a);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    load_a |=> pend_a);

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    irq_a |-> (pend_a && en_a));

  p_slow_rate_r6: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && !hs && count_en) |=> !count_en);

  p_evt_no_b_r8: assert property (@(posedge clk) disable iff (rst)
    (is_evt && !pend_b) |=> !pend_b);

  p_clear_low_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !pwm_out);

  p_stopped_r12: assert property (@(posedge clk) disable iff (rst)
    (!is_pwm && !is_evt) |-> !count_en);
endmodule

bind dual_reload_timer drt_checker #(.W(W)) u_drt_checker (
  .clk      (clk),
  .rst      (rst),
  .pwm_out  (pwm_out),
  .irq_a    (irq_a),
  .pend_a   (pend_a),
  .pend_b   (pend_b),
  .clr_a    (clr_a),
  .en_a     (en_a),
  .hs       (hs),
  .tog_en   (tog_en),
  .is_pwm   (is_pwm),
  .is_evt   (is_evt),
  .ctrl_wr  (ctrl_wr),
  .uflow    (uflow),
  .load_a   (load_a),
  .count_en (count_en),
  .preset_we(preset_we),
  .cnt      (cnt)
);

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ev_in = 1'b0;
  logic        pwm_out, irq_a, irq_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_reload_timer i_dual_reload_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_in(ev_in), .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl(input int mode, input bit tog, input bit ea,
                                      input bit eb, input bit hs);
    return 16'(mode) | (16'(tog) << 3) | (16'(ea) << 4) | (16'(eb) << 5) | (16'(hs) << 6);
  endfunction

  task automatic wait_out(input logic v);
    for (int i = 0; i < 200 && pwm_out != v; i++) @(negedge clk);
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (pwm_out == v && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse();
    @(negedge clk); ev_in = 1'b1;
    repeat (4) @(negedge clk);
    ev_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 pwm_out after reset", pwm_out, 0);
    check("R10 irq_a after reset", irq_a, 0);
    check("R10 irq_b after reset", irq_b, 0);
  endtask

  task automatic t_stopped();
    wr(3'd4, 16'd0);
    wr(3'd2, ctl(0, 1, 1, 1, 1));
    repeat (30) @(negedge clk);
    check("R12 no underflow when stopped", irq_a, 0);
    check("R12 output holds when stopped", pwm_out, 0);
  endtask

  task automatic t_pwm_fast();
    int hi, lo;
    wr(3'd0, 16'd3); wr(3'd1, 16'd1); wr(3'd4, 16'd0); wr(3'd3, 16'd3);
    wr(3'd2, ctl(1, 1, 1, 1, 1));
    @(negedge clk);
    check("R2 no underflow yet", irq_a, 0);
    @(negedge clk);
    check("R2 first underflow sets flag A", irq_a, 1);
    check("R2 first underflow not from B", irq_b, 0);
    check("R3 first underflow raises output", pwm_out, 1);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    check("R1 R3 high phase A+1 fast steps", hi, 4);
    check("R1 R3 low phase B+1 fast steps", lo, 2);
    check("R4 reload from B sets flag B", irq_b, 1);
  endtask

  task automatic t_pend_enables();
    wr(3'd2, ctl(0, 0, 0, 0, 1));
    @(negedge clk);
    check("R5 irq_a masked by enable", irq_a, 0);
    check("R5 irq_b masked by enable", irq_b, 0);
    wr(3'd2, ctl(0, 0, 1, 0, 1));
    @(negedge clk);
    check("R4 flag A held while masked", irq_a, 1);
    wr(3'd3, 16'd1);
    @(negedge clk);
    check("R4 clear drops flag A", irq_a, 0);
    wr(3'd2, ctl(0, 0, 1, 1, 1));
    @(negedge clk);
    check("R4 flag B untouched by clear A", irq_b, 1);
    wr(3'd3, 16'd2);
    @(negedge clk);
    check("R4 clear drops flag B", irq_b, 0);
  endtask

  task automatic t_pwm_slow();
    int hi, lo;
    wr(3'd0, 16'd2); wr(3'd1, 16'd4); wr(3'd4, 16'd0);
    wr(3'd2, ctl(1, 1, 0, 0, 0));
    wait_out(1'b1);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    check("R6 slow high phase 3 x 10 clocks", hi, 30);
    check("R6 slow low phase 5 x 10 clocks", lo, 50);
  endtask

  task automatic t_restart();
    int hi;
    wr(3'd0, 16'd3); wr(3'd1, 16'd1); wr(3'd4, 16'd0);
    wr(3'd2, ctl(1, 1, 0, 0, 1));
    wait_out(1'b1);
    wr(3'd2, ctl(1, 1, 0, 0, 1));
    @(negedge clk);
    check("R9 control write drives output low", pwm_out, 0);
    wait_out(1'b1);
    run_len(1'b1, hi);
    check("R9 restart reloads from A next", hi, 4);
  endtask

  task automatic t_collision();
    wr(3'd2, ctl(0, 0, 1, 0, 1));
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd0);
    wr(3'd2, ctl(1, 1, 1, 0, 1));
    wr(3'd3, 16'd1);
    @(negedge clk);
    check("R4 set wins over same-cycle clear", irq_a, 1);
    wr(3'd2, ctl(0, 0, 1, 0, 1));
    wr(3'd4, 16'd5);
    wr(3'd3, 16'd1);
    @(negedge clk);
    check("R11 preset write priority, flag clear", irq_a, 0);
  endtask

  task automatic t_event_rise();
    wr(3'd0, 16'd7); wr(3'd1, 16'd1); wr(3'd4, 16'd2); wr(3'd3, 16'd3);
    wr(3'd2, ctl(2, 1, 1, 1, 0));
    pulse(); pulse();
    check("R7 two rising edges no underflow", irq_a, 0);
    pulse();
    check("R7 third rising edge underflows", irq_a, 1);
    check("R8 event never sets flag B", irq_b, 0);
    check("R8 event never toggles output", pwm_out, 0);
    wr(3'd3, 16'd1);
    for (int i = 0; i < 7; i++) pulse();
    check("R8 reload from A=7 counts 8 edges", irq_a, 0);
    pulse();
    check("R8 eighth edge underflows", irq_a, 1);
    check("R8 flag B still clear", irq_b, 0);
  endtask

  task automatic t_event_fall();
    wr(3'd4, 16'd0); wr(3'd3, 16'd3);
    wr(3'd2, ctl(3, 0, 1, 0, 0));
    @(negedge clk); ev_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 rising edge ignored in falling mode", irq_a, 0);
    ev_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 falling edge counts", irq_a, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_stopped();
    t_pwm_fast();
    t_pend_enables();
    t_pwm_slow();
    t_restart();
    t_collision();
    t_event_rise();
    t_event_fall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule